// File: doc/BRIEF.md
# Serial Command Port for a Byte Register Space

This block is a serial peripheral slave that lets an external controller reach a 256-byte register space through four commands. It runs in mode 0 with an active-low select. Every group of eight bits is taken most significant bit first. The first byte of a frame is an opcode. Two opcodes take an address byte next. The other two start at a fixed address and carry data at once. Every command may run on into a burst. The register address steps by one after each data byte and wraps from 255 to 0.

All serial pins are brought into the system clock domain through synchronizer chains, and their edges are detected there. Writes leave the block as a one-cycle strobe carrying an address and a data byte. Reads are issued as a one-cycle fetch strobe. The register file answers one cycle later, and the byte is shifted out after the serial clock's falling edges. The register file and the meaning of its registers lie outside this block.

States: IDLE (select high), CMD (collecting the opcode), WADDR and RADDR (collecting an address for a write or a read burst), WDATA and RDATA (burst data), SKIP (unknown opcode, waiting for deselect). Transitions: IDLE→CMD when select falls. CMD→WADDR on 0x02, CMD→RADDR on 0x03, CMD→RDATA on 0x05, CMD→WDATA on 0x07 and CMD→SKIP on any other byte. WADDR→WDATA and RADDR→RDATA when the address byte completes. Any state→IDLE when select rises.

Top module: `spi_regif`

## Requirements
- R1: Opcode 0x02 followed by an address byte A and a data byte D produces one write strobe with address A and data D; bits are sampled on rising serial clock edges, most significant bit first.
- R2: Further data bytes in the same frame produce further write strobes at addresses A+1, A+2, and so on.
- R3: Opcode 0x03 followed by address A shifts out the register bytes at A, A+1, and so on, most significant bit first, with the output changing only after falling serial clock edges.
- R4: Opcode 0x05 carries no address; reading starts at address 240.
- R5: Opcode 0x07 carries no address; writing starts at address 244.
- R6: The burst address wraps from 255 to 0 for both reads and writes.
- R7: Any other opcode causes no write or fetch strobe, and the data output stays 0 until select rises.
- R8: A byte left incomplete when select rises is discarded. It produces no strobe and does not disturb the next frame.
- R9: The output enable is high exactly while the synchronized select is low. While the enable is low the data output is 0.
- R10: Write and fetch strobes last one system cycle and are never high together.
- R11: A fetch is issued one system cycle after each read address byte or read data byte completes, the last byte included, so a burst of n bytes fetches n+1 addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the data out driver |
| reg_addr | output | 8 | Register address for the current strobe |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_re | output | 1 | Fetch strobe, one cycle |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_re |

## Verification
An input edge reaches the edge detector two synchronizer stages plus one register later. A write or fetch strobe therefore appears one system cycle after the eighth rising edge of a byte is detected, about four cycles after the pin moves. The fetched byte is loaded two cycles after that. A new output bit appears about three cycles after a falling pin edge. The bench runs the serial clock at ten system cycles per half period and reads the output at the next rising edge, well after it settles. Strobes are checked at the falling system clock edge by a monitor that compares them in order against queues the driver fills, so no fixed latency is assumed beyond this ordering.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OPC_WR_ADDR  = 8'h02;
    localparam byte_t OPC_RD_ADDR  = 8'h03;
    localparam byte_t OPC_RD_FIXED = 8'h05;
    localparam byte_t OPC_WR_FIXED = 8'h07;

    localparam byte_t BASE_RD_FIXED = 8'd240;
    localparam byte_t BASE_WR_FIXED = 8'd244;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WADDR,
        ST_RADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } fe_state_t;

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic cs_n_pin,
    input  logic mosi_pin,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_bit
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] RST_VAL = 3'b010;   // select idles high

    logic [NPIN-1:0]   pin_in;
    logic [STAGES-1:0] chain [NPIN];
    logic              sclk_last;

    assign pin_in = {mosi_pin, cs_n_pin, sclk_pin};

    for (genvar p = 0; p < NPIN; p++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain[p] <= {STAGES{RST_VAL[p]}};
            else
                chain[p] <= {chain[p][STAGES-2:0], pin_in[p]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_last <= 1'b0;
        else        sclk_last <= chain[0][STAGES-1];
    end

    assign sclk_rise = chain[0][STAGES-1] & ~sclk_last;
    assign sclk_fall = ~chain[0][STAGES-1] & sclk_last;
    assign cs_active = ~chain[1][STAGES-1];
    assign mosi_bit  = chain[2][STAGES-1];

endmodule

// File: rtl/spi_regif_fsm.sv
module spi_regif_fsm
    import spi_regif_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_active,
    input  logic  sclk_rise,
    input  logic  mosi_bit,
    output byte_t reg_addr,
    output byte_t reg_wdata,
    output logic  reg_we,
    output logic  reg_re
);
    fe_state_t   state, state_nx;
    logic [2:0]  bit_cnt;
    logic [6:0]  rx_sh;
    logic        byte_done;
    byte_t       rx_byte;

    assign rx_byte   = {rx_sh, mosi_bit};
    assign byte_done = cs_active && sclk_rise && (bit_cnt == 3'd7);

    always_comb begin
        state_nx = state;
        if (!cs_active) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_CMD;
                ST_CMD: if (byte_done) begin
                    case (rx_byte)
                        OPC_WR_ADDR:  state_nx = ST_WADDR;
                        OPC_RD_ADDR:  state_nx = ST_RADDR;
                        OPC_RD_FIXED: state_nx = ST_RDATA;
                        OPC_WR_FIXED: state_nx = ST_WDATA;
                        default:      state_nx = ST_SKIP;
                    endcase
                end
                ST_WADDR: if (byte_done) state_nx = ST_WDATA;
                ST_RADDR: if (byte_done) state_nx = ST_RDATA;
                ST_WDATA, ST_RDATA, ST_SKIP: state_nx = state;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (reg_we || reg_re)
                reg_addr <= reg_addr + 8'd1;
            if (!cs_active) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
            end else if (sclk_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                rx_sh   <= rx_byte[6:0];
            end
            if (byte_done) begin
                unique case (state)
                    ST_CMD: begin
                        if (rx_byte == OPC_RD_FIXED) begin
                            reg_addr <= BASE_RD_FIXED;
                            reg_re   <= 1'b1;
                        end else if (rx_byte == OPC_WR_FIXED) begin
                            reg_addr <= BASE_WR_FIXED;
                        end
                    end
                    ST_WADDR: reg_addr <= rx_byte;
                    ST_RADDR: begin
                        reg_addr <= rx_byte;
                        reg_re   <= 1'b1;
                    end
                    ST_WDATA: begin
                        reg_we    <= 1'b1;
                        reg_wdata <= rx_byte;
                    end
                    ST_RDATA: reg_re <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re)); // R10
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R10
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> (!reg_we && !reg_re)); // R7
    AST_STATUS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && byte_done && rx_byte == OPC_RD_FIXED) |=> (reg_re && reg_addr == BASE_RD_FIXED)); // R4
    AST_INSTR_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && byte_done && rx_byte == OPC_WR_FIXED) |=> (reg_addr == BASE_WR_FIXED && !reg_we)); // R5
    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'hFF) |=> (reg_addr == 8'h00)); // R6
    AST_FETCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && byte_done) |=> reg_re); // R11

endmodule

// File: rtl/spi_regif_tx.sv
module spi_regif_tx
    import spi_regif_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  fetch,
    input  byte_t rdata,
    input  logic  sclk_fall,
    output logic  miso_bit
);
    logic  load_q;
    byte_t tx_sh;
    logic  miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else begin
            load_q <= fetch && !clear;
            if (clear) begin
                tx_sh  <= '0;
                miso_q <= 1'b0;
            end else if (load_q) begin
                tx_sh <= rdata;
            end else if (sclk_fall) begin
                miso_q <= tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso_bit = miso_q;

    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !sclk_fall) |=> $stable(miso_q)); // R3

endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       reg_re,
    input  logic [7:0] reg_rdata
);
    logic sclk_rise, sclk_fall, cs_active, mosi_bit, miso_bit;

    spi_regif_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_pin  (spi_sclk),
        .cs_n_pin  (spi_cs_n),
        .mosi_pin  (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_active (cs_active),
        .mosi_bit  (mosi_bit)
    );

    spi_regif_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sclk_rise (sclk_rise),
        .mosi_bit  (mosi_bit),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re)
    );

    spi_regif_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!cs_active),
        .fetch     (reg_re),
        .rdata     (reg_rdata),
        .sclk_fall (sclk_fall),
        .miso_bit  (miso_bit)
    );

    assign spi_miso_oe = cs_active;
    assign spi_miso    = miso_bit & cs_active;

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso); // R9

endmodule

// File: tb/spi_regif_test.sv
module spi_regif_test;
    localparam int HALF = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;

    always #2 clk = ~clk;

    spi_regif uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] model(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h3C;
    endfunction

    always_ff @(posedge clk) if (reg_re) reg_rdata <= model(reg_addr);

    logic [7:0] wq_addr[$], wq_data[$], rq_addr[$];
    string      wq_tag[$], rq_tag[$];
    int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0, wd_fail = 0;
    int we_cnt = 0, re_cnt = 0;
    bit done = 0;

    // monitor: scoreboard side
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            we_cnt++;
            m_chk++;
            if (wq_addr.size() == 0) begin
                m_fail++;
                $display("FAIL R7/R8 unexpected write: got %h<=%h expected none", reg_addr, reg_wdata);
            end else begin
                automatic logic [7:0] ea = wq_addr.pop_front();
                automatic logic [7:0] ed = wq_data.pop_front();
                automatic string      t  = wq_tag.pop_front();
                if (reg_addr !== ea || reg_wdata !== ed) begin
                    m_fail++;
                    $display("FAIL %s write: got %h<=%h expected %h<=%h", t, reg_addr, reg_wdata, ea, ed);
                end
            end
        end
        if (rst_n && reg_re) begin
            re_cnt++;
            m_chk++;
            if (rq_addr.size() == 0) begin
                m_fail++;
                $display("FAIL R7/R11 unexpected fetch: got %h expected none", reg_addr);
            end else begin
                automatic logic [7:0] ea = rq_addr.pop_front();
                automatic string      t  = rq_tag.pop_front();
                if (reg_addr !== ea) begin
                    m_fail++;
                    $display("FAIL %s fetch: got %h expected %h", t, reg_addr, ea);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_wr(input logic [7:0] a, input logic [7:0] d, input string t);
        wq_addr.push_back(a); wq_data.push_back(d); wq_tag.push_back(t);
    endtask

    task automatic push_rd(input logic [7:0] a, input string t);
        rq_addr.push_back(a); rq_tag.push_back(t);
    endtask

    task automatic sel;
        spi_cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic desel;
        #(HALF);
        spi_cs_n = 1'b1;
        #(3 * HALF);
    endtask

    task automatic xfer(input logic [7:0] mo, input int nb, output logic [7:0] mi);
        mi = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            spi_mosi = mo[i];
            #(HALF);
            spi_sclk = 1'b1;
            mi[i] = spi_miso;
            #(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed",
                 n_chk + m_chk - n_fail - m_fail - wd_fail, n_chk + m_chk + wd_fail);
    endtask

    initial begin
        #(600000);
        if (!done) begin
            wd_fail = 1;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] mi;
        int w0;
        #1;
        #(20);
        // reset state
        check(spi_miso_oe == 1'b0, "R9 reset oe", spi_miso_oe, 0);
        check(reg_we == 1'b0 && reg_re == 1'b0, "R10 reset strobes", {reg_we, reg_re}, 0);
        rst_n = 1'b1;
        #(40);

        // R1 single write
        push_wr(8'h10, 8'hA5, "R1");
        sel();
        check(spi_miso_oe == 1'b1, "R9 oe while selected", spi_miso_oe, 1);
        xfer(8'h02, 8, mi); xfer(8'h10, 8, mi); xfer(8'hA5, 8, mi);
        desel();
        check(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R9 oe after deselect", {spi_miso_oe, spi_miso}, 0);

        // R2 write burst
        push_wr(8'h20, 8'h11, "R2"); push_wr(8'h21, 8'h22, "R2"); push_wr(8'h22, 8'h33, "R2");
        sel();
        xfer(8'h02, 8, mi); xfer(8'h20, 8, mi);
        xfer(8'h11, 8, mi); xfer(8'h22, 8, mi); xfer(8'h33, 8, mi);
        desel();

        // R6 write wrap
        push_wr(8'hFE, 8'h01, "R6"); push_wr(8'hFF, 8'h02, "R6"); push_wr(8'h00, 8'h03, "R6");
        sel();
        xfer(8'h02, 8, mi); xfer(8'hFE, 8, mi);
        xfer(8'h01, 8, mi); xfer(8'h02, 8, mi); xfer(8'h03, 8, mi);
        desel();

        // R5 fixed-start write
        push_wr(8'd244, 8'hC3, "R5"); push_wr(8'd245, 8'h5A, "R5");
        sel();
        xfer(8'h07, 8, mi); xfer(8'hC3, 8, mi); xfer(8'h5A, 8, mi);
        desel();

        // R3 / R11 read burst
        for (int k = 0; k < 4; k++) push_rd(8'h40 + 8'(k), "R11");
        sel();
        xfer(8'h03, 8, mi);
        check(mi == 8'h00, "R3 idle output during opcode", mi, 0);
        xfer(8'h40, 8, mi);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, 8, mi);
            check(mi == model(8'h40 + 8'(k)), "R3 read byte", mi, model(8'h40 + 8'(k)));
        end
        desel();

        // R4 fixed-start read
        for (int k = 0; k < 3; k++) push_rd(8'd240 + 8'(k), "R4");
        sel();
        xfer(8'h05, 8, mi);
        for (int k = 0; k < 2; k++) begin
            xfer(8'h00, 8, mi);
            check(mi == model(8'd240 + 8'(k)), "R4 read byte", mi, model(8'd240 + 8'(k)));
        end
        desel();

        // R6 read wrap
        push_rd(8'hFF, "R6"); push_rd(8'h00, "R6"); push_rd(8'h01, "R6");
        sel();
        xfer(8'h03, 8, mi); xfer(8'hFF, 8, mi);
        xfer(8'h00, 8, mi);
        check(mi == model(8'hFF), "R6 read at 255", mi, model(8'hFF));
        xfer(8'h00, 8, mi);
        check(mi == model(8'h00), "R6 read after wrap", mi, model(8'h00));
        desel();

        // R7 unknown opcode
        w0 = we_cnt + re_cnt;
        sel();
        xfer(8'h55, 8, mi);
        xfer(8'hFF, 8, mi);
        check(mi == 8'h00, "R7 output quiet", mi, 0);
        xfer(8'h03, 8, mi);
        check(mi == 8'h00, "R7 output quiet", mi, 0);
        desel();
        check(we_cnt + re_cnt == w0, "R7 no strobes", we_cnt + re_cnt, w0);

        // R8 partial byte
        w0 = we_cnt;
        sel();
        xfer(8'h02, 8, mi); xfer(8'h30, 8, mi); xfer(8'hE0, 5, mi);
        desel();
        check(we_cnt == w0, "R8 partial byte dropped", we_cnt, w0);
        push_wr(8'h31, 8'h77, "R8");
        sel();
        xfer(8'h02, 8, mi); xfer(8'h31, 8, mi); xfer(8'h77, 8, mi);
        desel();
        check(we_cnt == w0 + 1, "R8 next frame clean", we_cnt, w0 + 1);

        #(200);
        check(wq_addr.size() == 0, "R1 R2 writes all seen", wq_addr.size(), 0);
        check(rq_addr.size() == 0, "R11 fetches all seen", rq_addr.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule